// File: doc/BRIEF.md
# Circular Interrupt Event Queue Writer

This block collects exception events raised by a set of channels and records each one as a 32-bit entry in one of four circular queues. The queues are held in a small on-chip entry RAM. Every channel owns a configuration word. That word picks one queue for its receive-direction events and one for its transmit-direction events. It also carries an enable bit for each of the eight event flags. An event whose enabled flags are all clear is consumed and leaves no trace. Any other event is written at the current write pointer of its queue, marked valid, and the pointer moves on.

Each queue's end is not given by a depth. It is marked by a wrap bit that software places in the last entry while it initialises the RAM. When the writer fills an entry carrying that bit, the pointer reloads the queue's base address. The writer keeps the wrap bit when it fills an entry. The writer never overwrites an entry that software has not yet cleared. In that case it raises a sticky per-queue overflow flag. By default the event is then discarded. With `HOLD_ON_FULL=1` the event is instead held back until the entry frees.

Software uses a single host port to initialise, read and release entries, to set queue bases and to restart a queue. Each channel presents its events over a valid/ready handshake. A channel raises `ev_valid` with its direction and flags and holds them unchanged until it sees `ev_ready` high at a clock edge. `ev_ready` is combinational from the current inputs. It is never high without `ev_valid` from the same channel. It stays low while the host port is busy. The fixed-priority grant can starve higher-numbered channels while a lower-numbered channel keeps requesting.

Top module: `iq_event_writer`

## Requirements
- R1: After reset, every overflow flag is 0, every entry RAM word reads 0, every channel configuration word is 0 (all flags disabled, both directions select queue 0), and queue q's base and write pointer equal q*16.
- R2: A written entry holds: bit 0 = 1 (valid), bit 1 = 0, bit 2 = the wrap bit that was already in that RAM word, bits 7:3 = 0, bits 15:8 = event flags AND channel enable mask, bits 31:16 = the channel number.
- R3: The configuration word is laid out with bits 1:0 = receive queue, bits 3:2 = transmit queue and bits 11:4 = per-flag enable mask. An event with `ev_dir`=0 goes to the receive queue and one with `ev_dir`=1 goes to the transmit queue.
- R4: An event whose masked flags are all zero is accepted (`ev_ready`=1) without writing any entry or moving any pointer.
- R5: After a write, the queue's pointer moves to the next address. If the written entry has its wrap bit set, the pointer instead returns to the queue's base.
- R6: If the entry at the pointer is already valid, it is left unchanged and the queue's overflow flag is set from the next cycle on. In the default drop mode, the event is accepted and discarded.
- R7: When several channels request in the same cycle, only the lowest-numbered one gets `ev_ready`, and at most one entry is written per cycle.
- R8: The host port has four operations, selected by `host_op`: 0 = idle, 1 = read, 2 = write a word, 3 = clear bit 0 of a word. Read data appears on `host_rdata` after the edge that samples the read. A clear leaves bits 31:1 unchanged.
- R9: In any cycle where `host_op` is not idle, no `ev_ready` is raised and the producer writes nothing.
- R10: A base write sets a queue's base without moving its pointer. A pulse on `q_srst[q]` loads pointer q from its base and clears overflow flag q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Channel configuration write strobe |
| cfg_ch | input | 3 | Channel whose configuration is written |
| cfg_wdata | input | 12 | Configuration word (layout in R3) |
| base_we | input | 1 | Queue base write strobe |
| base_q | input | 2 | Queue whose base is written |
| base_addr | input | 6 | New base address |
| q_srst | input | 4 | Per-queue pointer restart strobes |
| ev_valid | input | 8 | Per-channel event request |
| ev_ready | output | 8 | Per-channel event acceptance |
| ev_dir | input | 8 | Per-channel direction, 0 = receive, 1 = transmit |
| ev_flags | input | 64 | Eight event flags per channel, channel c at bits 8c+7:8c |
| host_op | input | 2 | Host operation (R8) |
| host_addr | input | 6 | Host RAM word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| q_ovf | output | 4 | Sticky per-queue overflow flags |

## Verification
An accepted event shows `ev_ready` high in the same cycle it is presented. Its entry is in the RAM after that clock edge. It can only be observed through a host read, which returns data one edge after the read is sampled. Overflow flags change one edge after the rejected write. The bench drives inputs on falling edges. It samples `ev_ready` 1 ns later within that same low phase. It samples read data and flags on the next falling edge, after the edge that produced them. Expected entries, pointers and flags come from a bench model that is updated only when an event is known to have been accepted.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int ENTRY_W   = 32;
  localparam int EV_FLAG_W = 8;
  localparam int VALID_BIT = 0;
  localparam int WRAP_BIT  = 2;
  localparam int CODE_W    = 16;

  typedef enum logic [1:0] {
    HOST_IDLE  = 2'd0,
    HOST_READ  = 2'd1,
    HOST_WRITE = 2'd2,
    HOST_CLEAR = 2'd3
  } host_op_e;

  function automatic logic [ENTRY_W-1:0] pack_entry(
    input logic [CODE_W-1:0]    code,
    input logic [EV_FLAG_W-1:0] flags,
    input logic                 wrap
  );
    return {code, flags, 5'b0, wrap, 1'b0, 1'b1};
  endfunction
endpackage

// File: rtl/iq_chan_cfg.sv
module iq_chan_cfg #(
  parameter int NUM_CH = 8,
  parameter int QSEL_W = 2,
  parameter int FLAG_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CFG_W = 2*QSEL_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CH_W-1:0]   wch,
  input  logic [CFG_W-1:0]  wdata,
  input  logic [CH_W-1:0]   sel_ch,
  input  logic              sel_dir,
  output logic [QSEL_W-1:0] sel_q,
  output logic [FLAG_W-1:0] sel_mask
);
  logic [QSEL_W-1:0] rxq_r  [NUM_CH];
  logic [QSEL_W-1:0] txq_r  [NUM_CH];
  logic [FLAG_W-1:0] mask_r [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rxq_r[c]  <= '0;
        txq_r[c]  <= '0;
        mask_r[c] <= '0;
      end else if (we && (wch == CH_W'(c))) begin
        rxq_r[c]  <= wdata[QSEL_W-1:0];
        txq_r[c]  <= wdata[2*QSEL_W-1:QSEL_W];
        mask_r[c] <= wdata[CFG_W-1:2*QSEL_W];
      end
    end
  end

  always_comb begin
    sel_q    = sel_dir ? txq_r[sel_ch] : rxq_r[sel_ch];
    sel_mask = mask_r[sel_ch];
  end
endmodule

// File: rtl/iq_prio_arb.sv
module iq_prio_arb #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             any
);
  always_comb begin
    logic found;
    found   = 1'b0;
    gnt     = '0;
    gnt_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i]  = 1'b1;
        gnt_idx = IDX_W'(i);
        found   = 1'b1;
      end
    end
    any = found;
  end
endmodule

// File: rtl/iq_ptr_bank.sv
module iq_ptr_bank #(
  parameter int NUM_Q = 4,
  parameter int AW    = 6,
  localparam int QSEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int SEG    = (1 << AW) / NUM_Q
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [QSEL_W-1:0] base_q,
  input  logic [AW-1:0]     base_addr,
  input  logic [NUM_Q-1:0]  srst,
  input  logic              adv,
  input  logic [QSEL_W-1:0] adv_q,
  input  logic              adv_wrap,
  input  logic              ovf_set,
  input  logic [QSEL_W-1:0] ovf_q,
  output logic [AW-1:0]     ptr [NUM_Q],
  output logic [NUM_Q-1:0]  ovf
);
  logic [AW-1:0] base_r [NUM_Q];

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic hit_adv, hit_ovf;
    assign hit_adv = adv && (adv_q == QSEL_W'(q));
    assign hit_ovf = ovf_set && (ovf_q == QSEL_W'(q));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_r[q] <= AW'(q * SEG);
        ptr[q]    <= AW'(q * SEG);
        ovf[q]    <= 1'b0;
      end else begin
        if (base_we && (base_q == QSEL_W'(q))) base_r[q] <= base_addr;
        if (srst[q]) begin
          ptr[q] <= base_r[q];
          ovf[q] <= 1'b0;
        end else begin
          if (hit_adv) ptr[q] <= adv_wrap ? base_r[q] : ptr[q] + 1'b1;
          if (hit_ovf) ovf[q] <= 1'b1;
        end
      end
    end

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_adv && !adv_wrap && !srst[q]) |=> (ptr[q] == $past(ptr[q]) + 1'b1));
    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_adv && adv_wrap && !srst[q] && !(base_we && base_q == QSEL_W'(q)))
      |=> (ptr[q] == base_r[q]));
    // R10
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst[q] |=> (!ovf[q] && ptr[q] == $past(base_r[q])));
  end
endmodule

// File: rtl/iq_entry_ram.sv
module iq_entry_ram
  import iq_pkg::*;
#(
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      p_addr,
  output logic [ENTRY_W-1:0] p_rdata,
  input  logic               p_we,
  input  logic [ENTRY_W-1:0] p_wdata,
  input  host_op_e           h_op,
  input  logic [AW-1:0]      h_addr,
  input  logic [ENTRY_W-1:0] h_wdata,
  output logic [ENTRY_W-1:0] h_rdata
);
  logic [ENTRY_W-1:0] mem [DEPTH];

  assign p_rdata = mem[p_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      h_rdata <= '0;
    end else begin
      unique case (h_op)
        HOST_READ:  h_rdata <= mem[h_addr];
        HOST_WRITE: mem[h_addr] <= h_wdata;
        HOST_CLEAR: mem[h_addr][VALID_BIT] <= 1'b0;
        default: ;
      endcase
      if (p_we) mem[p_addr] <= p_wdata;
    end
  end

  // R9
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_we |-> (h_op == HOST_IDLE));
  // R2
  entry_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_we |=> mem[$past(p_addr)][VALID_BIT]);
endmodule

// File: rtl/iq_event_writer.sv
module iq_event_writer
  import iq_pkg::*;
#(
  parameter int NUM_CH       = 8,
  parameter int NUM_Q        = 4,
  parameter int AW           = 6,
  parameter bit HOLD_ON_FULL = 1'b0,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int QSEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int CFG_W  = 2*QSEL_W + EV_FLAG_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [CH_W-1:0]             cfg_ch,
  input  logic [CFG_W-1:0]            cfg_wdata,
  input  logic                        base_we,
  input  logic [QSEL_W-1:0]           base_q,
  input  logic [AW-1:0]               base_addr,
  input  logic [NUM_Q-1:0]            q_srst,
  input  logic [NUM_CH-1:0]           ev_valid,
  output logic [NUM_CH-1:0]           ev_ready,
  input  logic [NUM_CH-1:0]           ev_dir,
  input  logic [NUM_CH*EV_FLAG_W-1:0] ev_flags,
  input  logic [1:0]                  host_op,
  input  logic [AW-1:0]               host_addr,
  input  logic [ENTRY_W-1:0]          host_wdata,
  output logic [ENTRY_W-1:0]          host_rdata,
  output logic [NUM_Q-1:0]            q_ovf
);
  host_op_e           h_op;
  logic               host_busy;
  logic [NUM_CH-1:0]  req, gnt;
  logic [CH_W-1:0]    gnt_idx;
  logic               gnt_any;
  logic [QSEL_W-1:0]  sel_q;
  logic [EV_FLAG_W-1:0] sel_mask, raw_flags, eff_flags;
  logic [AW-1:0]      ptr [NUM_Q];
  logic [AW-1:0]      cur_ptr;
  logic [ENTRY_W-1:0] cur_entry, new_entry;
  logic               has_flags, slot_busy, accept, do_write, do_ovf;

  assign h_op      = host_op_e'(host_op);
  assign host_busy = (h_op != HOST_IDLE);
  assign req       = host_busy ? '0 : ev_valid;

  iq_prio_arb #(.N(NUM_CH)) arb_i (
    .req(req), .gnt(gnt), .gnt_idx(gnt_idx), .any(gnt_any)
  );

  iq_chan_cfg #(.NUM_CH(NUM_CH), .QSEL_W(QSEL_W), .FLAG_W(EV_FLAG_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wch(cfg_ch), .wdata(cfg_wdata),
    .sel_ch(gnt_idx), .sel_dir(ev_dir[gnt_idx]),
    .sel_q(sel_q), .sel_mask(sel_mask)
  );

  always_comb begin
    raw_flags = ev_flags[gnt_idx*EV_FLAG_W +: EV_FLAG_W];
    eff_flags = raw_flags & sel_mask;
    has_flags = |eff_flags;
    cur_ptr   = ptr[sel_q];
    slot_busy = cur_entry[VALID_BIT];
    do_write  = gnt_any && has_flags && !slot_busy;
    do_ovf    = gnt_any && has_flags && slot_busy;
    accept    = gnt_any && !(HOLD_ON_FULL && do_ovf);
    ev_ready  = accept ? gnt : '0;
    new_entry = pack_entry(CODE_W'(gnt_idx), eff_flags, cur_entry[WRAP_BIT]);
  end

  iq_ptr_bank #(.NUM_Q(NUM_Q), .AW(AW)) ptr_i (
    .clk(clk), .rst_n(rst_n),
    .base_we(base_we), .base_q(base_q), .base_addr(base_addr),
    .srst(q_srst),
    .adv(do_write), .adv_q(sel_q), .adv_wrap(cur_entry[WRAP_BIT]),
    .ovf_set(do_ovf), .ovf_q(sel_q),
    .ptr(ptr), .ovf(q_ovf)
  );

  iq_entry_ram #(.AW(AW)) ram_i (
    .clk(clk), .rst_n(rst_n),
    .p_addr(cur_ptr), .p_rdata(cur_entry),
    .p_we(do_write), .p_wdata(new_entry),
    .h_op(h_op), .h_addr(host_addr), .h_wdata(host_wdata), .h_rdata(host_rdata)
  );

  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_ready));
  // R9
  host_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_op != 2'd0) |-> (ev_ready == '0));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ovf && !q_srst[sel_q]) |=> q_ovf[$past(sel_q)]);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ovf && HOLD_ON_FULL) |-> (ev_ready == '0));
  // R4
  no_flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any && !has_flags) |=> $stable(q_ovf));
endmodule

// File: tb/iq_event_writer_tb_top.sv
`timescale 1ns/1ps
module iq_event_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_ch;
  logic [11:0] cfg_wdata;
  logic        base_we;
  logic [1:0]  base_q;
  logic [5:0]  base_addr;
  logic [3:0]  q_srst;
  logic [7:0]  ev_valid, ev_ready, ev_dir;
  logic [63:0] ev_flags;
  logic [1:0]  host_op;
  logic [5:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic [3:0]  q_ovf;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mem_m [64];
  logic [5:0]  ptr_m [4];
  logic [5:0]  base_m [4];
  logic [1:0]  rxq_m [8];
  logic [1:0]  txq_m [8];
  logic [7:0]  mask_m [8];
  logic [3:0]  ovf_m;

  always #2.5 clk = ~clk;

  iq_event_writer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_wdata(cfg_wdata),
    .base_we(base_we), .base_q(base_q), .base_addr(base_addr), .q_srst(q_srst),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_dir(ev_dir), .ev_flags(ev_flags),
    .host_op(host_op), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .q_ovf(q_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] entry_of(input int ch, input logic [7:0] f, input logic w);
    return {16'(ch), f, 5'b0, w, 1'b0, 1'b1};
  endfunction

  // bench model of one accepted event
  task automatic model_ev(input int ch, input logic dir, input logic [7:0] flags);
    logic [1:0] q;
    logic [7:0] m;
    logic [5:0] p;
    q = dir ? txq_m[ch] : rxq_m[ch];
    m = flags & mask_m[ch];
    if (m == 8'h00) return;
    p = ptr_m[q];
    if (mem_m[p][0]) begin
      ovf_m[q] = 1'b1;
      return;
    end
    mem_m[p] = entry_of(ch, m, mem_m[p][2]);
    ptr_m[q] = mem_m[p][2] ? base_m[q] : p + 6'd1;
  endtask

  task automatic host_do(input logic [1:0] op, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    host_op = op; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_op = 2'd0;
    if (op == 2'd2) mem_m[a] = d;
    if (op == 2'd3) mem_m[a][0] = 1'b0;
  endtask

  task automatic host_rd(input logic [5:0] a, output logic [31:0] d);
    host_do(2'd1, a, 32'h0);
    d = host_rdata;
  endtask

  task automatic set_cfg(input int ch, input logic [1:0] rq, input logic [1:0] tq, input logic [7:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_wdata = {m, tq, rq};
    @(negedge clk);
    cfg_we = 1'b0;
    rxq_m[ch] = rq; txq_m[ch] = tq; mask_m[ch] = m;
  endtask

  task automatic send_ev(input int ch, input logic dir, input logic [7:0] flags, input string req);
    @(negedge clk);
    ev_valid[ch] = 1'b1; ev_dir[ch] = dir; ev_flags[ch*8 +: 8] = flags;
    #1;
    chk(req, 32'(ev_ready), 32'(8'(1) << ch));
    @(negedge clk);
    ev_valid[ch] = 1'b0;
    model_ev(ch, dir, flags);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_we = 0; cfg_ch = 0; cfg_wdata = 0; base_we = 0; base_q = 0;
    base_addr = 0; q_srst = 0; ev_valid = 0; ev_dir = 0; ev_flags = 0;
    host_op = 0; host_addr = 0; host_wdata = 0;
    for (int i = 0; i < 64; i++) mem_m[i] = 32'h0;
    for (int q = 0; q < 4; q++) begin ptr_m[q] = 6'(q*16); base_m[q] = 6'(q*16); end
    for (int c = 0; c < 8; c++) begin rxq_m[c] = 0; txq_m[c] = 0; mask_m[c] = 0; end
    ovf_m = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 ovf", 32'(q_ovf), 32'h0);
    chk("R1 ready", 32'(ev_ready), 32'h0);
    host_rd(6'd5, rd);
    chk("R1 ram", rd, 32'h0);

    // R4: reset config masks everything
    send_ev(0, 1'b0, 8'hFF, "R4 ready");
    host_rd(6'd0, rd);
    chk("R4 no write", rd, 32'h0);

    // initialise wrap bits: short queue 1 ends at 18
    for (int a = 0; a < 64; a++)
      host_do(2'd2, 6'(a), (a == 15 || a == 18 || a == 47 || a == 63) ? 32'h4 : 32'h0);

    // R3/R2 queue select and entry format
    set_cfg(0, 2'd1, 2'd2, 8'h0F);
    set_cfg(3, 2'd0, 2'd2, 8'hF0);
    send_ev(0, 1'b0, 8'h31, "R3 rx ready");
    host_rd(6'd16, rd);
    chk("R2 entry rx q1", rd, 32'h0000_0101);
    send_ev(3, 1'b1, 8'hA5, "R3 tx ready");
    host_rd(6'd32, rd);
    chk("R3 tx q2 entry", rd, 32'h0003_A001);
    send_ev(0, 1'b0, 8'hF0, "R4 masked ready");
    host_rd(6'd17, rd);
    chk("R4 masked no write", rd, 32'h0);

    // R5 wrap and R6 overflow on short queue 1
    send_ev(0, 1'b0, 8'h02, "R5 ready");
    send_ev(0, 1'b0, 8'h04, "R5 ready");
    host_rd(6'd18, rd);
    chk("R2 wrap kept", rd, 32'h0000_0405);
    send_ev(0, 1'b0, 8'h08, "R6 drop ready");
    host_rd(6'd16, rd);
    chk("R6 not overwritten", rd, 32'h0000_0101);
    chk("R6 ovf", 32'(q_ovf), 32'h2);
    host_do(2'd3, 6'd16, 32'h0);
    host_rd(6'd16, rd);
    chk("R8 clear bit0", rd, 32'h0000_0100);
    send_ev(0, 1'b0, 8'h08, "R5 ready");
    host_rd(6'd16, rd);
    chk("R5 wrapped to base", rd, 32'h0000_0801);

    // R7 priority: ch2 and ch5 both to queue 3
    set_cfg(2, 2'd3, 2'd3, 8'hFF);
    set_cfg(5, 2'd3, 2'd3, 8'hFF);
    @(negedge clk);
    ev_valid[2] = 1; ev_dir[2] = 0; ev_flags[23:16] = 8'h11;
    ev_valid[5] = 1; ev_dir[5] = 1; ev_flags[47:40] = 8'h22;
    #1 chk("R7 lowest first", 32'(ev_ready), 32'h04);
    @(negedge clk);
    ev_valid[2] = 0;
    model_ev(2, 1'b0, 8'h11);
    #1 chk("R7 next", 32'(ev_ready), 32'h20);
    @(negedge clk);
    ev_valid[5] = 0;
    model_ev(5, 1'b1, 8'h22);
    host_rd(6'd48, rd);
    chk("R7 first entry", rd, 32'h0002_1101);
    host_rd(6'd49, rd);
    chk("R7 second entry", rd, 32'h0005_2201);

    // R9 host access stalls producer
    @(negedge clk);
    ev_valid[2] = 1; ev_dir[2] = 0; ev_flags[23:16] = 8'h40;
    host_op = 2'd1; host_addr = 6'd0;
    #1 chk("R9 stalled", 32'(ev_ready), 32'h0);
    @(negedge clk);
    host_op = 2'd0;
    #1 chk("R9 resumes", 32'(ev_ready), 32'h04);
    @(negedge clk);
    ev_valid[2] = 0;
    model_ev(2, 1'b0, 8'h40);
    host_rd(6'd50, rd);
    chk("R9 entry after stall", rd, 32'h0002_4001);

    // R10 base write and per-queue restart
    @(negedge clk);
    base_we = 1; base_q = 2'd0; base_addr = 6'd8;
    @(negedge clk);
    base_we = 0; base_m[0] = 6'd8;
    set_cfg(1, 2'd0, 2'd0, 8'hFF);
    send_ev(1, 1'b0, 8'h01, "R10 ready");
    host_rd(6'd0, rd);
    chk("R10 base alone no move", rd, 32'h0001_0101);
    @(negedge clk);
    q_srst = 4'b0011;
    @(negedge clk);
    q_srst = 4'b0;
    ptr_m[0] = base_m[0]; ptr_m[1] = base_m[1]; ovf_m[1:0] = 2'b00;
    chk("R10 ovf cleared", 32'(q_ovf), 32'(ovf_m));
    send_ev(1, 1'b0, 8'h02, "R10 ready");
    host_rd(6'd8, rd);
    chk("R10 restart at base", rd, 32'h0001_0201);

    // random phase
    for (int c = 0; c < 8; c++)
      set_cfg(c, 2'($urandom), 2'($urandom), 8'($urandom));
    for (int n = 0; n < 120; n++) begin
      if ($urandom % 5 == 0) host_do(2'd3, 6'($urandom), 32'h0);
      else send_ev(int'($urandom % 8), 1'($urandom), 8'($urandom), "R2 R5 R6 random ready");
    end
    for (int a = 0; a < 64; a++) begin
      host_rd(6'(a), rd);
      chk("R2 R5 R6 random entry", rd, mem_m[a]);
    end
    chk("R6 random ovf", 32'(q_ovf), 32'(ovf_m));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule